// File: doc/BRIEF.md
# Transactional Conflict Responder and Resolver

This per-core block settles data conflicts between hardware transactions. As a responder, it answers coherence requests that the directory forwards to this core. It looks at whether the line is present, at the line's read and write marks, and at a sticky overflow flag. The overflow flag records that a marked line has left the cache during the current transaction. From these it answers with an acknowledge, a refusal (NACK), or a clean-up message that tells the directory its record is stale.

As a requester, it handles refusals of the core's own requests. By default the core stalls and tries again after an exponential backoff. An abort trap is raised only when deadlock is possible: the refusing transaction must be logically earlier than this core's own, and this core must earlier have refused a logically earlier transaction. That second condition is held in a possible-cycle flag.

Transactions are ordered by a timestamp taken from a per-core counter at the outermost begin, with the core number breaking ties. A transaction restarted after an abort keeps its timestamp. The block also tracks the nesting depth of transactions.

Top module: `tx_conflict_unit`

## Requirements
- R1: A forwarded read-shared request (kind code 0) to a present line is answered NACK when the line's write mark is set, and ACK when only the read mark or no mark is set. Response codes are ACK=1, NACK=2, CLEAN=3, and no response is 0. The response appears in the cycle after the request is sampled.
- R2: A forwarded exclusive request (kind code 1) or invalidation (kind code 2) to a present line is answered NACK when its read or write mark is set, and ACK when neither is set.
- R3: A forwarded request of any kind to a line that is not present is answered NACK while the overflow flag is set.
- R4: A forwarded request to a line that is not present is answered CLEAN while the overflow flag is clear. This holds whether or not the core is in a transaction.
- R5: The overflow flag is set by an eviction of a line with a read or write mark while in a transaction, and is not set by an eviction of an unmarked line. It clears at the outermost commit and at abort completion.
- R6: Each begin raises the nesting depth and each commit lowers it. The core is in a transaction while the depth is non-zero. An inner commit leaves the transaction state untouched.
- R7: A fresh outermost begin takes the current value of the stamp counter, which is 0 after reset and increments with each fresh outermost begin. An inner begin leaves the stamp unchanged. The first outermost begin after an abort completion reuses the previous stamp.
- R8: Transaction A is earlier than B when A's stamp is smaller, or when the stamps are equal and A's core number is lower. The possible-cycle flag is set when this core, while in a transaction, sends a NACK to an in-transaction requester that is earlier than this core's transaction.
- R9: The possible-cycle flag clears at the outermost commit and at abort completion.
- R10: A NACK to the core's own request raises a single-cycle abort trap, and no retry, only when the core is in a transaction, the possible-cycle flag is set, and the refusing transaction is earlier.
- R11: Any other NACK produces a single-cycle retry exactly W cycles after the NACK is sampled. W starts at 16 and doubles with each further NACK up to 1024. A successful completion resets W to 16.
- R12: After reset there is no response, no retry, no trap, no transaction, the stamp is 0, and both flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_begin | input | 1 | Begin instruction retired |
| tx_commit | input | 1 | Commit instruction retired |
| abort_done | input | 1 | Software abort handler finished |
| evict_valid | input | 1 | A cache line is being evicted |
| evict_marked | input | 1 | Evicted line has a read or write mark |
| fwd_valid | input | 1 | Forwarded coherence request present |
| fwd_kind | input | 2 | 0 read-shared, 1 exclusive, 2 invalidate |
| fwd_hit | input | 1 | Requested line is present locally |
| fwd_rd | input | 1 | Read mark of the present line |
| fwd_wr | input | 1 | Write mark of the present line |
| fwd_req_tx | input | 1 | Requester is inside a transaction |
| fwd_ts | input | TS_W | Requester's transaction stamp |
| fwd_id | input | ID_W | Requester's core number |
| rsp_valid | output | 1 | Response to a forwarded request |
| rsp_code | output | 2 | 1 ACK, 2 NACK, 3 CLEAN |
| own_nack | input | 1 | Own request was refused |
| own_nack_ts | input | TS_W | Stamp of the refusing transaction |
| own_nack_id | input | ID_W | Core number of the refusing core |
| own_done | input | 1 | Own request completed successfully |
| retry | output | 1 | Pulse: re-issue the request |
| abort_trap | output | 1 | Pulse: trap to the abort handler |
| in_tx | output | 1 | Core is inside a transaction |
| tx_stamp | output | TS_W | Current transaction stamp |
| overflow | output | 1 | A marked line was evicted this transaction |
| possible_cycle | output | 1 | Core has refused an earlier transaction |

## Verification
Several checks run on every cycle. The registered response must follow the mark and overflow rules for each request kind. Retry and trap must never coincide, and a trap needs the possible-cycle flag set one cycle before. Both flags must be clear after commit or abort, the stamp must hold while a transaction is open, and the backoff window must stay within its bounds. Only the bench's scenarios can show the rest: the exact retry latency as the window doubles and saturates, the tie-breaking by core number, stamp reuse after an abort, and the sticky flags persisting across inner commits during random sequences.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
  typedef enum logic [1:0] {
    RSP_NONE  = 2'd0,
    RSP_ACK   = 2'd1,
    RSP_NACK  = 2'd2,
    RSP_CLEAN = 2'd3
  } rsp_e;

  localparam logic [1:0] KIND_GETS = 2'd0;

  // A earlier than B: lower stamp, then lower core number
  function automatic logic ts_before(input logic [31:0] a_ts, input logic [31:0] a_id,
                                     input logic [31:0] b_ts, input logic [31:0] b_id);
    return (a_ts < b_ts) || ((a_ts == b_ts) && (a_id < b_id));
  endfunction

  // doubling backoff window with saturation at cap (power of two)
  function automatic logic [31:0] win_next(input logic [31:0] w, input logic [31:0] cap);
    return (w >= (cap >> 1)) ? cap : (w << 1);
  endfunction

  function automatic rsp_e decide(input logic [1:0] kind, input logic hit,
                                  input logic rd, input logic wr, input logic ovf);
    logic clash;
    if (hit) begin
      clash = (kind == KIND_GETS) ? wr : (rd | wr);
      return clash ? RSP_NACK : RSP_ACK;
    end
    return ovf ? RSP_NACK : RSP_CLEAN;
  endfunction
endpackage

// File: rtl/tcr_txstate.sv
module tcr_txstate #(
  parameter int TS_W    = 12,
  parameter int DEPTH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            begin_i,
  input  logic            commit_i,
  input  logic            abort_done_i,
  input  logic            evict_i,
  input  logic            evict_marked_i,
  input  logic            pc_set_i,
  output logic            in_tx_o,
  output logic [TS_W-1:0] stamp_o,
  output logic            ovf_o,
  output logic            pc_o
);
  localparam logic [DEPTH_W-1:0] DEPTH_MAX = {DEPTH_W{1'b1}};
  localparam logic [DEPTH_W-1:0] DEPTH_ONE = DEPTH_W'(1);

  logic [DEPTH_W-1:0] depth;
  logic [TS_W-1:0]    ctr;
  logic               keep_stamp;
  logic               outer_commit;
  logic               fresh_begin;

  assign outer_commit = commit_i && !abort_done_i && (depth == DEPTH_ONE);
  assign fresh_begin  = begin_i && !commit_i && !abort_done_i && (depth == '0);
  assign in_tx_o      = (depth != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth      <= '0;
      ctr        <= '0;
      stamp_o    <= '0;
      keep_stamp <= 1'b0;
      ovf_o      <= 1'b0;
      pc_o       <= 1'b0;
    end else if (abort_done_i) begin
      depth      <= '0;
      keep_stamp <= 1'b1;
      ovf_o      <= 1'b0;
      pc_o       <= 1'b0;
    end else begin
      if (evict_i && evict_marked_i && in_tx_o) ovf_o <= 1'b1;
      if (pc_set_i && in_tx_o) pc_o <= 1'b1;
      if (commit_i) begin
        if (depth != '0) depth <= depth - DEPTH_ONE;
        if (outer_commit) begin
          keep_stamp <= 1'b0;
          ovf_o      <= 1'b0;
          pc_o       <= 1'b0;
        end
      end else if (begin_i && depth != DEPTH_MAX) begin
        depth <= depth + DEPTH_ONE;
        if (fresh_begin && !keep_stamp) begin
          stamp_o <= ctr;
          ctr     <= ctr + TS_W'(1);
        end
      end
    end
  end

  // R7: the stamp holds while a transaction is open
  a_r7_stamp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    in_tx_o |=> $stable(stamp_o));
  // R9: possible-cycle flag cleared after outermost commit
  a_r9_pc_commit: assert property (@(posedge clk) disable iff (!rst_n)
    outer_commit |=> !pc_o);
  // R5: overflow and transaction state cleared after abort completion
  a_r5_ovf_abort: assert property (@(posedge clk) disable iff (!rst_n)
    abort_done_i |=> (!ovf_o && !in_tx_o && !pc_o));
  // R6: an inner commit keeps the core in its transaction
  a_r6_inner_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && !abort_done_i && depth > DEPTH_ONE) |=> in_tx_o);
endmodule

// File: rtl/tcr_responder.sv
module tcr_responder
  import tcr_pkg::*;
#(
  parameter int TS_W    = 12,
  parameter int ID_W    = 3,
  parameter int CORE_ID = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fwd_valid_i,
  input  logic [1:0]      fwd_kind_i,
  input  logic            fwd_hit_i,
  input  logic            fwd_rd_i,
  input  logic            fwd_wr_i,
  input  logic            fwd_req_tx_i,
  input  logic [TS_W-1:0] fwd_ts_i,
  input  logic [ID_W-1:0] fwd_id_i,
  input  logic            in_tx_i,
  input  logic [TS_W-1:0] stamp_i,
  input  logic            ovf_i,
  output logic            rsp_valid_o,
  output logic [1:0]      rsp_code_o,
  output logic            pc_set_o
);
  rsp_e dec;
  rsp_e rsp_q;
  logic nack_now;
  logic req_earlier;

  assign dec         = decide(fwd_kind_i, fwd_hit_i, fwd_rd_i, fwd_wr_i, ovf_i);
  assign nack_now    = fwd_valid_i && (dec == RSP_NACK);
  assign req_earlier = ts_before(32'(fwd_ts_i), 32'(fwd_id_i), 32'(stamp_i), 32'(CORE_ID));
  assign pc_set_o    = nack_now && fwd_req_tx_i && in_tx_i && req_earlier;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_q       <= RSP_NONE;
    end else begin
      rsp_valid_o <= fwd_valid_i;
      rsp_q       <= fwd_valid_i ? dec : RSP_NONE;
    end
  end
  assign rsp_code_o = rsp_q;

  // R1: shared request to a written line is refused
  a_r1_gets_write: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid_i && fwd_hit_i && fwd_kind_i == KIND_GETS && fwd_wr_i) |=> rsp_code_o == RSP_NACK);
  // R2: exclusive or invalidate to a read line is refused
  a_r2_excl_read: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid_i && fwd_hit_i && fwd_kind_i != KIND_GETS && fwd_rd_i) |=> rsp_code_o == RSP_NACK);
  // R3: absent line with overflow is refused
  a_r3_absent_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid_i && !fwd_hit_i && ovf_i) |=> rsp_code_o == RSP_NACK);
  // R4: absent line without overflow gets clean-up
  a_r4_absent_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid_i && !fwd_hit_i && !ovf_i) |=> rsp_code_o == RSP_CLEAN);
  // R12: no response without a request
  a_r12_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_valid_i |=> !rsp_valid_o);
endmodule

// File: rtl/tcr_requester.sv
module tcr_requester
  import tcr_pkg::*;
#(
  parameter int TS_W    = 12,
  parameter int ID_W    = 3,
  parameter int CORE_ID = 0,
  parameter int BO_MIN  = 16,
  parameter int BO_MAX  = 1024
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            nack_i,
  input  logic [TS_W-1:0] nack_ts_i,
  input  logic [ID_W-1:0] nack_id_i,
  input  logic            done_i,
  input  logic            abort_done_i,
  input  logic            in_tx_i,
  input  logic [TS_W-1:0] stamp_i,
  input  logic            pc_i,
  output logic            retry_o,
  output logic            trap_o
);
  localparam int CNT_W = $clog2(BO_MAX + 1);
  localparam logic [CNT_W-1:0] WIN_MIN = CNT_W'(BO_MIN);
  localparam logic [CNT_W-1:0] WIN_MAX = CNT_W'(BO_MAX);

  typedef enum logic [1:0] {RQ_IDLE, RQ_WAIT, RQ_TRAP} rq_e;
  rq_e             st;
  logic [CNT_W-1:0] win;
  logic [CNT_W-1:0] cnt;
  logic            nacker_first;
  logic            take_trap;
  logic            take_wait;

  assign nacker_first = ts_before(32'(nack_ts_i), 32'(nack_id_i), 32'(stamp_i), 32'(CORE_ID));
  assign take_trap    = nack_i && (st == RQ_IDLE) && in_tx_i && pc_i && nacker_first;
  assign take_wait    = nack_i && (st == RQ_IDLE) && !take_trap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= RQ_IDLE;
      win     <= WIN_MIN;
      cnt     <= '0;
      retry_o <= 1'b0;
      trap_o  <= 1'b0;
    end else begin
      retry_o <= 1'b0;
      trap_o  <= 1'b0;
      case (st)
        RQ_IDLE: begin
          if (take_trap) begin
            trap_o <= 1'b1;
            st     <= RQ_TRAP;
          end else if (take_wait) begin
            cnt <= win - CNT_W'(1);
            win <= CNT_W'(win_next(32'(win), 32'(BO_MAX)));
            st  <= RQ_WAIT;
          end
        end
        RQ_WAIT: begin
          if (cnt == '0) begin
            retry_o <= 1'b1;
            st      <= RQ_IDLE;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: if (abort_done_i) st <= RQ_IDLE;
      endcase
      if (done_i) win <= WIN_MIN;
    end
  end

  // R10: retry and trap are exclusive
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(retry_o && trap_o));
  // R10: a trap needs the possible-cycle flag and an open transaction
  a_r10_trap_cond: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> ($past(pc_i) && $past(in_tx_i) && $past(nack_i)));
  // R11: window stays within bounds
  a_r11_win_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (win >= WIN_MIN) && (win <= WIN_MAX));
  // R11: retry only leaves the waiting state
  a_r11_retry_src: assert property (@(posedge clk) disable iff (!rst_n)
    retry_o |-> $past(st == RQ_WAIT));
endmodule

// File: rtl/tx_conflict_unit.sv
module tx_conflict_unit #(
  parameter int TS_W    = 12,
  parameter int ID_W    = 3,
  parameter int CORE_ID = 0,
  parameter int DEPTH_W = 4,
  parameter int BO_MIN  = 16,
  parameter int BO_MAX  = 1024
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tx_begin,
  input  logic            tx_commit,
  input  logic            abort_done,
  input  logic            evict_valid,
  input  logic            evict_marked,
  input  logic            fwd_valid,
  input  logic [1:0]      fwd_kind,
  input  logic            fwd_hit,
  input  logic            fwd_rd,
  input  logic            fwd_wr,
  input  logic            fwd_req_tx,
  input  logic [TS_W-1:0] fwd_ts,
  input  logic [ID_W-1:0] fwd_id,
  output logic            rsp_valid,
  output logic [1:0]      rsp_code,
  input  logic            own_nack,
  input  logic [TS_W-1:0] own_nack_ts,
  input  logic [ID_W-1:0] own_nack_id,
  input  logic            own_done,
  output logic            retry,
  output logic            abort_trap,
  output logic            in_tx,
  output logic [TS_W-1:0] tx_stamp,
  output logic            overflow,
  output logic            possible_cycle
);
  logic pc_set;

  tcr_txstate #(.TS_W(TS_W), .DEPTH_W(DEPTH_W)) u_state (
    .clk(clk), .rst_n(rst_n),
    .begin_i(tx_begin), .commit_i(tx_commit), .abort_done_i(abort_done),
    .evict_i(evict_valid), .evict_marked_i(evict_marked), .pc_set_i(pc_set),
    .in_tx_o(in_tx), .stamp_o(tx_stamp), .ovf_o(overflow), .pc_o(possible_cycle)
  );

  tcr_responder #(.TS_W(TS_W), .ID_W(ID_W), .CORE_ID(CORE_ID)) u_resp (
    .clk(clk), .rst_n(rst_n),
    .fwd_valid_i(fwd_valid), .fwd_kind_i(fwd_kind), .fwd_hit_i(fwd_hit),
    .fwd_rd_i(fwd_rd), .fwd_wr_i(fwd_wr), .fwd_req_tx_i(fwd_req_tx),
    .fwd_ts_i(fwd_ts), .fwd_id_i(fwd_id),
    .in_tx_i(in_tx), .stamp_i(tx_stamp), .ovf_i(overflow),
    .rsp_valid_o(rsp_valid), .rsp_code_o(rsp_code), .pc_set_o(pc_set)
  );

  tcr_requester #(.TS_W(TS_W), .ID_W(ID_W), .CORE_ID(CORE_ID),
                  .BO_MIN(BO_MIN), .BO_MAX(BO_MAX)) u_req (
    .clk(clk), .rst_n(rst_n),
    .nack_i(own_nack), .nack_ts_i(own_nack_ts), .nack_id_i(own_nack_id),
    .done_i(own_done), .abort_done_i(abort_done),
    .in_tx_i(in_tx), .stamp_i(tx_stamp), .pc_i(possible_cycle),
    .retry_o(retry), .trap_o(abort_trap)
  );

  // R8: the possible-cycle flag only rises together with a refusal being sent
  a_r8_pc_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(possible_cycle) |-> (rsp_valid && rsp_code == 2'd2));
endmodule

// File: tb/tx_conflict_unit_test.sv
module tx_conflict_unit_test;
  localparam int TS_W = 12;
  localparam int ID_W = 3;
  localparam int MY_ID = 3;

  logic clk = 0;
  logic rst_n = 0;
  logic tx_begin = 0, tx_commit = 0, abort_done = 0, evict_valid = 0, evict_marked = 0;
  logic fwd_valid = 0, fwd_hit = 0, fwd_rd = 0, fwd_wr = 0, fwd_req_tx = 0;
  logic [1:0] fwd_kind = 0;
  logic [TS_W-1:0] fwd_ts = 0;
  logic [ID_W-1:0] fwd_id = 0;
  logic rsp_valid;
  logic [1:0] rsp_code;
  logic own_nack = 0, own_done = 0;
  logic [TS_W-1:0] own_nack_ts = 0;
  logic [ID_W-1:0] own_nack_id = 0;
  logic retry, abort_trap, in_tx, overflow, possible_cycle;
  logic [TS_W-1:0] tx_stamp;

  int checks = 0;
  int errors = 0;

  tx_conflict_unit #(.TS_W(TS_W), .ID_W(ID_W), .CORE_ID(MY_ID)) uut (
    .clk(clk), .rst_n(rst_n), .tx_begin(tx_begin), .tx_commit(tx_commit),
    .abort_done(abort_done), .evict_valid(evict_valid), .evict_marked(evict_marked),
    .fwd_valid(fwd_valid), .fwd_kind(fwd_kind), .fwd_hit(fwd_hit), .fwd_rd(fwd_rd),
    .fwd_wr(fwd_wr), .fwd_req_tx(fwd_req_tx), .fwd_ts(fwd_ts), .fwd_id(fwd_id),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .own_nack(own_nack),
    .own_nack_ts(own_nack_ts), .own_nack_id(own_nack_id), .own_done(own_done),
    .retry(retry), .abort_trap(abort_trap), .in_tx(in_tx), .tx_stamp(tx_stamp),
    .overflow(overflow), .possible_cycle(possible_cycle)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic do_begin();  tx_begin = 1; cyc(); tx_begin = 0; endtask
  task automatic do_commit(); tx_commit = 1; cyc(); tx_commit = 0; endtask
  task automatic do_evict(input logic m);
    evict_valid = 1; evict_marked = m; cyc(); evict_valid = 0; evict_marked = 0;
  endtask
  task automatic do_fwd(input logic [1:0] k, input logic h, input logic r, input logic w,
                        input logic rt, input int ts, input int id);
    fwd_valid = 1; fwd_kind = k; fwd_hit = h; fwd_rd = r; fwd_wr = w;
    fwd_req_tx = rt; fwd_ts = TS_W'(ts); fwd_id = ID_W'(id);
    cyc();
    fwd_valid = 0;
  endtask

  // cycles from the sampled nack to the retry pulse
  task automatic nack_latency(input int ts, input int id, output int n);
    own_nack = 1; own_nack_ts = TS_W'(ts); own_nack_id = ID_W'(id);
    cyc();
    own_nack = 0;
    n = 0;
    while (!retry && n < 3000) begin cyc(); n++; end
  endtask

  function automatic bit earlier(input int ats, input int aid, input int bts, input int bid);
    return (ats < bts) || (ats == bts && aid < bid);
  endfunction

  function automatic int exp_rsp(input int k, input bit h, input bit r, input bit w, input bit ovf);
    if (h) begin
      if (k == 0) return w ? 2 : 1;
      return (r || w) ? 2 : 1;
    end
    return ovf ? 2 : 3;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int w;
    int m_depth, m_ctr, m_stamp;
    bit m_ovf, m_pc;
    void'($urandom(32'd1234));
    repeat (3) cyc();
    // R12 reset state
    check("R12 rsp_valid", int'(rsp_valid), 0);
    check("R12 in_tx", int'(in_tx), 0);
    check("R12 flags", int'({overflow, possible_cycle, retry, abort_trap}), 0);
    check("R12 stamp", int'(tx_stamp), 0);
    rst_n = 1; cyc();

    do_begin();
    check("R6 in_tx after begin", int'(in_tx), 1);
    check("R7 first stamp", int'(tx_stamp), 0);
    do_begin();
    check("R7 inner begin stamp", int'(tx_stamp), 0);
    do_fwd(0, 1, 0, 1, 0, 0, 0);
    check("R1 gets write nack", int'(rsp_code), 2);
    check("R8 non-tx requester no flag", int'(possible_cycle), 0);
    do_fwd(0, 1, 1, 0, 0, 0, 0);
    check("R1 gets read ack", int'(rsp_code), 1);
    do_fwd(1, 1, 1, 0, 0, 0, 0);
    check("R2 getx read nack", int'(rsp_code), 2);
    do_fwd(2, 1, 0, 0, 0, 0, 0);
    check("R2 inv clean line ack", int'(rsp_code), 1);
    do_fwd(2, 1, 0, 1, 0, 0, 0);
    check("R2 inv written nack", int'(rsp_code), 2);
    do_evict(0);
    check("R5 unmarked evict", int'(overflow), 0);
    do_evict(1);
    check("R5 marked evict", int'(overflow), 1);
    do_fwd(0, 0, 0, 0, 0, 0, 0);
    check("R3 absent overflow nack", int'(rsp_code), 2);
    do_commit();
    check("R6 inner commit in_tx", int'(in_tx), 1);
    check("R6 inner commit overflow kept", int'(overflow), 1);
    do_commit();
    check("R6 outer commit", int'(in_tx), 0);
    check("R5 commit clears overflow", int'(overflow), 0);
    do_fwd(1, 0, 0, 0, 0, 0, 0);
    check("R4 absent idle clean", int'(rsp_code), 3);

    do_begin();
    check("R7 fresh stamp", int'(tx_stamp), 1);
    do_fwd(0, 0, 0, 0, 1, 0, 0);
    check("R4 absent in tx clean", int'(rsp_code), 3);
    do_fwd(1, 1, 0, 1, 1, 5, 0);
    check("R8 later requester", int'(possible_cycle), 0);
    do_fwd(1, 1, 0, 1, 1, 1, 4);
    check("R8 tie higher id later", int'(possible_cycle), 0);
    do_fwd(1, 1, 0, 1, 1, 1, 2);
    check("R8 tie lower id earlier", int'(possible_cycle), 1);
    nack_latency(9, 0, n);
    check("R11 later nacker retries after 16", n, 16);
    check("R10 no trap for later nacker", int'(abort_trap), 0);
    own_nack = 1; own_nack_ts = TS_W'(1); own_nack_id = ID_W'(1);
    cyc(); own_nack = 0;
    check("R10 trap raised", int'(abort_trap), 1);
    n = 0;
    for (int i = 0; i < 40; i++) begin cyc(); if (retry || abort_trap) n++; end
    check("R10 trap single no retry", n, 0);
    abort_done = 1; cyc(); abort_done = 0;
    check("R9 abort clears flag", int'(possible_cycle), 0);
    check("R6 abort ends tx", int'(in_tx), 0);
    do_begin();
    check("R7 restart keeps stamp", int'(tx_stamp), 1);
    do_fwd(0, 1, 0, 1, 1, 0, 0);
    check("R8 earlier stamp sets flag", int'(possible_cycle), 1);
    do_commit();
    check("R9 commit clears flag", int'(possible_cycle), 0);
    do_begin();
    check("R7 next fresh stamp", int'(tx_stamp), 2);
    do_commit();

    own_done = 1; cyc(); own_done = 0;
    w = 16;
    for (int i = 0; i < 8; i++) begin
      nack_latency(0, 0, n);
      check("R11 backoff window", n, w);
      w = (w >= 512) ? 1024 : w * 2;
    end
    own_done = 1; cyc(); own_done = 0;
    nack_latency(0, 0, n);
    check("R11 window reset on success", n, 16);

    // random phase against a bench model, from a fresh reset
    rst_n = 0; cyc(); cyc(); rst_n = 1; cyc();
    m_depth = 0; m_ctr = 0; m_stamp = 0; m_ovf = 0; m_pc = 0;
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom % 8);
      if (op == 0 && m_depth < 3) begin
        do_begin();
        if (m_depth == 0) begin m_stamp = m_ctr; m_ctr++; end
        m_depth++;
      end else if (op == 1) begin
        do_commit();
        if (m_depth == 1) begin m_ovf = 0; m_pc = 0; end
        if (m_depth > 0) m_depth--;
      end else if (op == 2) begin
        bit mk;
        mk = 1'($urandom % 2);
        do_evict(mk);
        if (mk && m_depth > 0) m_ovf = 1;
      end else begin
        int k, ts, id, e;
        bit h, r, wv, rt;
        k = int'($urandom % 3); h = 1'($urandom % 2); r = 1'($urandom % 2);
        wv = 1'($urandom % 2); rt = 1'($urandom % 2);
        ts = int'($urandom % (m_ctr + 2)); id = int'($urandom % 8);
        e = exp_rsp(k, h, r, wv, m_ovf);
        do_fwd(2'(k), h, r, wv, rt, ts, id);
        check("R1 R2 R3 R4 random response", int'(rsp_code), e);
        if (e == 2 && rt && m_depth > 0 && earlier(ts, id, m_stamp, MY_ID)) m_pc = 1;
      end
      check("R8 R9 random flag", int'(possible_cycle), int'(m_pc));
      check("R5 random overflow", int'(overflow), int'(m_ovf));
      check("R6 random in_tx", int'(in_tx), int'(m_depth > 0));
      if (m_depth > 0) check("R7 random stamp", int'(tx_stamp), m_stamp);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule